// File: doc/BRIEF.md
# Forwarding Width Guard with Zero-Extension Masking

This block sits beside a result bypass network and decides whether a result still in flight can be handed straight to a dependent instruction when the two instructions work on different operand sizes. Each instruction carries a 3-bit thermometer size vector and a SIMD flag. A SIMD operation always covers the whole register, so its flag widens its effective width to full. Forwarding the raw word is safe only if the consumer reads no more bits than the producer wrote.

The block also zero-extends results. There is one masking unit on the forwarding path and one at each of two register write ports. Each unit takes only a size vector and a SIMD flag and builds its own mask. A mode input picks how the bypass behaves. In masked mode, the forwarded word is zero-extended, so forwarding is always allowed. In unmasked mode, an unsafe dependent pair raises a stall request for one cycle. That stall is cheaper than scheduling a separate zero-extend operation.

All outputs are combinational from the inputs except the stall, which also depends on a one-bit history register. The block has no back-pressure: each result is due in the same cycle as its stimulus, so no valid/ready handshake is used. The producer's result word, the write-port data and the control pins are plain signals.

Top module: `bypass_width_guard`

## Requirements
- R1: A non-SIMD size vector selects a width. 3'b000 selects 8 bits, 3'b001 selects 16, 3'b011 selects 32 and 3'b111 selects 64. Every other vector selects 64. A masked output keeps the bits below the selected width and drives every higher bit to zero.
- R2: When the SIMD flag of a masking unit is 1, its output equals its input word unchanged, whatever the size vector.
- R3: In unmasked mode (`masked_mode`=0) with `dep_hit`=1, `byp_ok` is 1 exactly when (~Ep & Ec) == 3'b000. Here Ep = `prod_size` | {3{`prod_simd`}} and Ec = `cons_size` | {3{`cons_simd`}}.
- R4: In unmasked mode with `dep_hit`=1 and the R3 condition false, `stall_req` is 1 in that same cycle, unless R5 or R10 applies.
- R5: `stall_req` is never 1 in two consecutive cycles. In the cycle after a stall it stays 0 even if the blocking condition persists. If the condition is still present in the cycle after that, it may assert again.
- R6: When `masked_mode`=1, `byp_ok` is 1 and `stall_req` is 0.
- R7: When `dep_hit`=0, `byp_ok` is 1 and `stall_req` is 0.
- R8: `fwd_data` equals `prod_result` masked by the producer's size and SIMD flag when `masked_mode`=1, and equals the raw `prod_result` when `masked_mode`=0.
- R9: Write port k uses bits [3k+2:3k] of `wp_size`, bit k of `wp_simd` and bits [64k+63:64k] of `wp_data` and `wp_out`. The two ports mask independently, with different sizes in the same cycle.
- R10: `rst` is synchronous and active high. While it is high, `stall_req` is 0. It clears the stall history, so a stall may assert in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| masked_mode | input | 1 | 1: the forwarding path zero-extends; 0: raw forwarding with stall |
| dep_hit | input | 1 | Consumer depends on the in-flight producer (computed elsewhere) |
| prod_size | input | 3 | Producer thermometer size vector |
| prod_simd | input | 1 | Producer SIMD flag |
| cons_size | input | 3 | Consumer thermometer size vector |
| cons_simd | input | 1 | Consumer SIMD flag |
| prod_result | input | 64 | Producer result word |
| byp_ok | output | 1 | Forwarding permitted for this pair |
| stall_req | output | 1 | One-cycle stall request |
| fwd_data | output | 64 | Value placed on the forwarding path |
| wp_size | input | 6 | Size vectors of the two write ports, 3 bits each |
| wp_simd | input | 2 | SIMD flags of the two write ports |
| wp_data | input | 128 | Write data of the two ports, 64 bits each |
| wp_out | output | 128 | Masked write data of the two ports |

## Verification
Every result is due in the same cycle as the stimulus that causes it. The masks, `byp_ok`, `fwd_data` and the write-port outputs have no register on their path. `stall_req` is also same-cycle, but it depends on whether the previous cycle stalled. The driver applies each stimulus one time unit after a rising edge and records its expected values. The expected stall uses a model of the previous cycle's expected stall. The monitor compares at the following falling edge, before the next rising edge can update the stall history. Held blocking pairs and pairs driven during and right after reset check the one-cycle history.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    WID_8    = 2'd0,
    WID_16   = 2'd1,
    WID_32   = 2'd2,
    WID_FULL = 2'd3
  } wid_cls_e;

  // Thermometer vector plus SIMD flag -> width class; malformed codes -> full
  function automatic wid_cls_e decode_width(input logic [SIZE_W-1:0] sz, input logic simd);
    wid_cls_e c;
    if (simd) c = WID_FULL;
    else begin
      unique case (sz)
        3'b000:  c = WID_8;
        3'b001:  c = WID_16;
        3'b011:  c = WID_32;
        default: c = WID_FULL;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/bwg_mask_unit.sv
module bwg_mask_unit
  import bwg_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [SIZE_W-1:0] size_v,
  input  logic              simd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANE0_W = 8;

  wid_cls_e          cls;
  logic [DATA_W-1:0] keep;
  int                lim;

  always_comb begin
    cls = decode_width(size_v, simd);
    lim = LANE0_W << int'(cls);
    for (int i = 0; i < DATA_W; i++) begin
      keep[i] = (cls == WID_FULL) || (i < lim);
    end
  end

  assign dout = din & keep;
endmodule

// File: rtl/bwg_width_cmp.sv
module bwg_width_cmp
  import bwg_pkg::*;
(
  input  logic [SIZE_W-1:0] p_size,
  input  logic              p_simd,
  input  logic [SIZE_W-1:0] c_size,
  input  logic              c_simd,
  output logic              fits
);
  logic [SIZE_W-1:0] eff_p, eff_c;

  assign eff_p = p_size | {SIZE_W{p_simd}};
  assign eff_c = c_size | {SIZE_W{c_simd}};
  // Consumer must not need a bit position the producer did not write
  assign fits  = ((~eff_p) & eff_c) == '0;
endmodule

// File: rtl/bwg_stall_ctl.sv
module bwg_stall_ctl (
  input  logic clk,
  input  logic rst,
  input  logic need,
  output logic stall_req
);
  logic stalled_q;

  assign stall_req = need & ~stalled_q & ~rst;

  always_ff @(posedge clk) begin
    if (rst) stalled_q <= 1'b0;
    else     stalled_q <= stall_req;
  end
endmodule

// File: rtl/bypass_width_guard.sv
module bypass_width_guard
  import bwg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_WP = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     masked_mode,
  input  logic                     dep_hit,
  input  logic [2:0]               prod_size,
  input  logic                     prod_simd,
  input  logic [2:0]               cons_size,
  input  logic                     cons_simd,
  input  logic [DATA_W-1:0]        prod_result,
  output logic                     byp_ok,
  output logic                     stall_req,
  output logic [DATA_W-1:0]        fwd_data,
  input  logic [NUM_WP*3-1:0]      wp_size,
  input  logic [NUM_WP-1:0]        wp_simd,
  input  logic [NUM_WP*DATA_W-1:0] wp_data,
  output logic [NUM_WP*DATA_W-1:0] wp_out
);
  logic              fits;
  logic              need_stall;
  logic [DATA_W-1:0] fwd_masked;

  bwg_width_cmp u_cmp (
    .p_size (prod_size),
    .p_simd (prod_simd),
    .c_size (cons_size),
    .c_simd (cons_simd),
    .fits   (fits)
  );

  assign byp_ok     = masked_mode | ~dep_hit | fits;
  assign need_stall = dep_hit & ~masked_mode & ~fits;

  bwg_stall_ctl u_stall (
    .clk       (clk),
    .rst       (rst),
    .need      (need_stall),
    .stall_req (stall_req)
  );

  bwg_mask_unit #(.DATA_W(DATA_W)) u_fwd_mask (
    .size_v (prod_size),
    .simd   (prod_simd),
    .din    (prod_result),
    .dout   (fwd_masked)
  );

  assign fwd_data = masked_mode ? fwd_masked : prod_result;

  for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
    bwg_mask_unit #(.DATA_W(DATA_W)) u_wp_mask (
      .size_v (wp_size[k*SIZE_W +: SIZE_W]),
      .simd   (wp_simd[k]),
      .din    (wp_data[k*DATA_W +: DATA_W]),
      .dout   (wp_out[k*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/bwg_checker.sv
module bwg_checker #(
  parameter int DATA_W = 64,
  parameter int NUM_WP = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     masked_mode,
  input logic                     dep_hit,
  input logic [DATA_W-1:0]        prod_result,
  input logic                     byp_ok,
  input logic                     stall_req,
  input logic [DATA_W-1:0]        fwd_data,
  input logic [NUM_WP*3-1:0]      wp_size,
  input logic [NUM_WP-1:0]        wp_simd,
  input logic [NUM_WP*DATA_W-1:0] wp_data,
  input logic [NUM_WP*DATA_W-1:0] wp_out
);
  p_masked_mode_free_r6: assert property (@(posedge clk) disable iff (rst)
    masked_mode |-> (byp_ok && !stall_req));

  p_no_hit_free_r7: assert property (@(posedge clk) disable iff (rst)
    !dep_hit |-> (byp_ok && !stall_req));

  p_stall_only_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    stall_req |-> !byp_ok);

  p_stall_single_r5: assert property (@(posedge clk) disable iff (rst)
    stall_req |=> !stall_req);

  p_simd_passes_r2: assert property (@(posedge clk) disable iff (rst)
    wp_simd[0] |-> (wp_out[DATA_W-1:0] == wp_data[DATA_W-1:0]));

  p_byte_clears_high_r1: assert property (@(posedge clk) disable iff (rst)
    (!wp_simd[0] && wp_size[2:0] == 3'b000) |-> (wp_out[DATA_W-1:8] == '0));

  p_raw_forward_r8: assert property (@(posedge clk) disable iff (rst)
    !masked_mode |-> (fwd_data == prod_result));
endmodule

bind bypass_width_guard bwg_checker #(.DATA_W(DATA_W), .NUM_WP(NUM_WP)) i_bwg_checker (
  .clk         (clk),
  .rst         (rst),
  .masked_mode (masked_mode),
  .dep_hit     (dep_hit),
  .prod_result (prod_result),
  .byp_ok      (byp_ok),
  .stall_req   (stall_req),
  .fwd_data    (fwd_data),
  .wp_size     (wp_size),
  .wp_simd     (wp_simd),
  .wp_data     (wp_data),
  .wp_out      (wp_out)
);

// File: tb/test_bypass_width_guard.sv
`timescale 1ns/1ps
module test_bypass_width_guard;
  localparam int DW = 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           masked_mode = 1'b0, dep_hit = 1'b0;
  logic [2:0]     prod_size = '0, cons_size = '0;
  logic           prod_simd = 1'b0, cons_simd = 1'b0;
  logic [DW-1:0]  prod_result = '0;
  logic           byp_ok, stall_req;
  logic [DW-1:0]  fwd_data;
  logic [5:0]     wp_size = '0;
  logic [1:0]     wp_simd = '0;
  logic [2*DW-1:0] wp_data = '0;
  logic [2*DW-1:0] wp_out;

  always #2 clk = ~clk;

  bypass_width_guard i_bypass_width_guard (
    .clk(clk), .rst(rst), .masked_mode(masked_mode), .dep_hit(dep_hit),
    .prod_size(prod_size), .prod_simd(prod_simd), .cons_size(cons_size),
    .cons_simd(cons_simd), .prod_result(prod_result), .byp_ok(byp_ok),
    .stall_req(stall_req), .fwd_data(fwd_data), .wp_size(wp_size),
    .wp_simd(wp_simd), .wp_data(wp_data), .wp_out(wp_out)
  );

  typedef struct {
    string         tag;
    logic          ok;
    logic          stall;
    logic [DW-1:0] fwd;
    logic [DW-1:0] w0;
    logic [DW-1:0] w1;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_err = 0;
  logic prev_stall = 1'b0;
  bit   done = 0;

  function automatic logic [DW-1:0] ref_mask(input logic [2:0] s, input logic simd, input logic [DW-1:0] d);
    int w;
    if (simd) w = 64;
    else if (s == 3'b000) w = 8;
    else if (s == 3'b001) w = 16;
    else if (s == 3'b011) w = 32;
    else w = 64;
    if (w >= DW) return d;
    return d & ((64'd1 << w) - 64'd1);
  endfunction

  task automatic drive(input string tag, input logic r, input logic mm, input logic dh,
                       input logic [2:0] ps, input logic psi, input logic [2:0] cs, input logic csi,
                       input logic [DW-1:0] pr, input logic [2:0] s0, input logic si0,
                       input logic [2:0] s1, input logic si1, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    exp_t e;
    logic [2:0] ep, ec;
    logic fit, need;
    @(posedge clk); #1;
    rst = r; masked_mode = mm; dep_hit = dh;
    prod_size = ps; prod_simd = psi; cons_size = cs; cons_simd = csi; prod_result = pr;
    wp_size = {s1, s0}; wp_simd = {si1, si0}; wp_data = {d1, d0};
    ep = ps | {3{psi}};
    ec = cs | {3{csi}};
    fit = ((~ep) & ec) == 3'b000;
    need = dh && !mm && !fit;
    e.tag = tag;
    e.ok = mm || !dh || fit;
    e.stall = need && !prev_stall && !r;
    e.fwd = mm ? ref_mask(ps, psi, pr) : pr;
    e.w0 = ref_mask(s0, si0, d0);
    e.w1 = ref_mask(s1, si1, d1);
    prev_stall = r ? 1'b0 : e.stall;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string fld, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  // Monitor: compare at the falling edge of the cycle the stimulus was applied
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "byp_ok", {63'd0, byp_ok}, {63'd0, e.ok});
      cmp(e.tag, "stall_req", {63'd0, stall_req}, {63'd0, e.stall});
      cmp(e.tag, "fwd_data", fwd_data, e.fwd);
      cmp(e.tag, "wp_out0", wp_out[DW-1:0], e.w0);
      cmp(e.tag, "wp_out1", wp_out[2*DW-1:DW], e.w1);
    end
  end

  localparam logic [DW-1:0] PAT = 64'hA5C3_9F17_6E2B_D480;
  localparam logic [DW-1:0] PB  = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    // R10: reset asserted with a blocking pair -> no stall
    drive("R10_in_reset", 1, 0, 1, 3'b001, 0, 3'b011, 0, PAT, 3'b000, 0, 3'b000, 0, PB, PB);
    // R10/R4: first cycle after release stalls at once
    drive("R10_R4_release", 0, 0, 1, 3'b001, 0, 3'b011, 0, PAT, 3'b000, 0, 3'b001, 0, PB, PB);
    // R5: held pair -> no stall in the next cycle
    drive("R5_hold", 0, 0, 1, 3'b001, 0, 3'b011, 0, PAT, 3'b011, 0, 3'b111, 0, PAT, PAT);
    // R5: still held -> may stall again
    drive("R5_again", 0, 0, 1, 3'b001, 0, 3'b011, 0, PAT, 3'b011, 0, 3'b111, 0, PAT, PAT);
    // R3: narrower consumer fits
    drive("R3_fit", 0, 0, 1, 3'b111, 0, 3'b001, 0, PAT, 3'b001, 0, 3'b000, 0, PAT, PB);
    // R3: equal widths fit
    drive("R3_equal", 0, 0, 1, 3'b011, 0, 3'b011, 0, PAT, 3'b000, 0, 3'b011, 0, PAT, PB);
    // R3: SIMD producer covers any consumer
    drive("R3_simd_prod", 0, 0, 1, 3'b000, 1, 3'b111, 0, PAT, 3'b000, 1, 3'b000, 0, PAT, PAT);
    // R3/R4: SIMD consumer of a byte producer blocks
    drive("R3_simd_cons", 0, 0, 1, 3'b000, 0, 3'b000, 1, PAT, 3'b010, 0, 3'b101, 0, PAT, PB);
    // R6/R8: masked mode never stalls, forward zero-extended to 8 bits
    drive("R6_R8_masked", 0, 1, 1, 3'b000, 0, 3'b111, 0, PAT, 3'b001, 0, 3'b011, 1, PB, PAT);
    // R8: masked forward 32-bit producer
    drive("R8_masked32", 0, 1, 1, 3'b011, 0, 3'b001, 0, PB, 3'b011, 0, 3'b000, 0, PB, PB);
    // R8: masked forward SIMD producer passes
    drive("R8_masked_simd", 0, 1, 0, 3'b000, 1, 3'b000, 0, PAT, 3'b111, 0, 3'b110, 0, PAT, PAT);
    // R7: no dependency -> ok, no stall even for a blocking size pair
    drive("R7_nohit", 0, 0, 0, 3'b000, 0, 3'b111, 1, PAT, 3'b000, 1, 3'b001, 1, PAT, PB);
    // R4: fresh blocking pair after a non-stall cycle
    drive("R4_block16", 0, 0, 1, 3'b000, 0, 3'b001, 0, PAT, 3'b001, 0, 3'b011, 0, PB, PAT);
    // R1/R9: ports with different sizes same cycle; malformed code -> 64
    drive("R1_R9_ports", 0, 1, 0, 3'b111, 0, 3'b000, 0, PAT, 3'b100, 0, 3'b000, 0, PAT, PB);
    drive("R2_R9_simd", 0, 1, 0, 3'b001, 0, 3'b000, 0, PAT, 3'b000, 1, 3'b011, 0, PAT, PB);
    // R1: malformed producer code in masked mode forwards full word
    drive("R1_fwd_bad", 0, 1, 1, 3'b010, 0, 3'b111, 0, PB, 3'b110, 0, 3'b001, 0, PB, PAT);
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule